// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is a serial-peripheral slave that sits inside a larger design and takes short command words from an external controller. The controller lowers an active-low select line, sends exactly sixteen bits on a data line with the most significant bit first, and then raises the select line again. On that rising select edge the block splits the word into a 4-bit operation code (the top nibble) and a 12-bit operand (the low twelve bits). It presents both on its outputs with a strobe one system clock wide.

One operation code is reserved for writing the mode register. When a word carries that code, the low bits of its operand are stored in a register that holds the operating mode of the surrounding logic. Every other code is passed on through the command outputs and leaves the mode register alone. Nothing is sent back to the controller.

The serial clock, data and select lines are asynchronous to the system clock. Each passes through its own synchroniser, and all edges are detected in the system clock domain. For this reason the system clock must run at least four times faster than the serial clock. A select window that holds any bit count other than sixteen is thrown away.

Top module: `cmdrx_top`

## Requirements
- R1: While `spi_cs_n` is low, bits are captured on rising edges of `spi_sck`, which idles low. The first bit received becomes word bit 15 and the last becomes bit 0.
- R2: After an accepted word, `cmd_code` equals word bits 15..12 and `cmd_data` equals word bits 11..0.
- R3: `cmd_valid` goes high for exactly one system clock cycle. It rises within 4 system clock cycles after the synchronised rising edge of `spi_cs_n` that closes a window containing exactly 16 rising `spi_sck` edges.
- R4: A select window with fewer or more than 16 rising `spi_sck` edges raises no `cmd_valid`, and it leaves `cmd_code`, `cmd_data` and `mode_reg` unchanged.
- R5: An accepted word whose code equals `CFG_CODE` (default 4'h1) loads `cmd_data[CFG_W-1:0]` into `mode_reg`. The new value is visible in the cycle after `cmd_valid`.
- R6: An accepted word with any other code still raises `cmd_valid` and leaves `mode_reg` unchanged.
- R7: `cmd_code` and `cmd_data` hold the last accepted word until the next `cmd_valid`.
- R8: `spi_sck` edges that occur while `spi_cs_n` is high are ignored. They raise no strobe and do not change the outputs.
- R9: While `rst_n` is low, `cmd_valid`, `cmd_code`, `cmd_data` and `mode_reg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the controller, idle low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_cs_n | input | 1 | Active-low select that frames one word |
| cmd_valid | output | 1 | One-cycle strobe marking a new accepted word |
| cmd_code | output | CMD_W (4) | Operation code of the last accepted word |
| cmd_data | output | DATA_W (12) | Operand of the last accepted word |
| mode_reg | output | CFG_W (8) | Mode register loaded by the configuration code |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a 12-bit operand, an 8-bit mode register, two synchroniser stages and configuration code 1. It drives the serial clock at one eighth of the system clock, which leaves margin over the four-times limit. With these values every word boundary is reachable in a short run, including one bit too few, one bit too many and back-to-back frames. A mode write that is followed by a non-configuration word also shows that only the reserved code reaches the register.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

   // Width of a counter able to hold 0 .. n inclusive
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Idle levels seen by the synchronisers while in reset
   localparam logic IDLE_SCK  = 1'b0;
   localparam logic IDLE_MOSI = 1'b0;
   localparam logic IDLE_CSN  = 1'b1;

endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
   parameter int unsigned   WIDTH    = 3,
   parameter int unsigned   STAGES   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cmdrx_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
         else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/cmdrx_shifter.sv
module cmdrx_shifter #(
   parameter int unsigned WORD_W    = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              csn_s,
   output logic              word_vld_o,
   output logic [WORD_W-1:0] word_o
);
   import cmdrx_pkg::*;

   localparam int unsigned CNT_W = cnt_bits(WORD_W + 1);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] OVER  = CNT_W'(WORD_W + 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("cmdrx_shifter: WORD_W must be at least 2");
   end

   logic              sck_p, csn_p;
   logic [WORD_W-1:0] shreg_q, shreg_nx;
   logic [CNT_W-1:0]  cnt_q;
   logic              vld_q;
   logic [WORD_W-1:0] word_q;

   wire sck_rise = sck_s & ~sck_p;
   wire csn_fall = ~csn_s & csn_p;
   wire csn_rise = csn_s & ~csn_p;

   if (MSB_FIRST) begin : g_msb
      assign shreg_nx = {shreg_q[WORD_W-2:0], mosi_s};
   end else begin : g_lsb
      assign shreg_nx = {mosi_s, shreg_q[WORD_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p   <= IDLE_SCK;
         csn_p   <= IDLE_CSN;
         shreg_q <= '0;
         cnt_q   <= '0;
         vld_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         sck_p <= sck_s;
         csn_p <= csn_s;
         vld_q <= 1'b0;
         if (csn_fall) begin
            cnt_q <= '0;
         end else if (!csn_s && sck_rise) begin
            shreg_q <= shreg_nx;
            if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
         end
         if (csn_rise && cnt_q == FULL) begin
            vld_q  <= 1'b1;
            word_q <= shreg_q;
         end
      end
   end

   assign word_vld_o = vld_q;
   assign word_o     = word_q;

   // R3: the strobe never lasts beyond one cycle
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
   // R4: a strobe only follows a window that counted exactly WORD_W bits
   a_r4_full_word_only: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(cnt_q) == FULL);
   // R8: nothing shifts while the select is high
   a_r8_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> $stable(shreg_q));
   // R7: the presented word changes only together with the strobe
   a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q |-> $stable(word_q));

endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode #(
   parameter int unsigned      CMD_W    = 4,
   parameter int unsigned      DATA_W   = 12,
   parameter int unsigned      CFG_W    = 8,
   parameter logic [CMD_W-1:0] CFG_CODE = 4'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [CMD_W-1:0]  code_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CFG_W-1:0]  cfg_o
);

   if (CFG_W > DATA_W || CFG_W == 0) begin : g_bad_cfg
      $error("cmdrx_decode: CFG_W must be between 1 and DATA_W");
   end

   logic [CFG_W-1:0] cfg_q;
   wire  hit = vld_i && (code_i == CFG_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q <= '0;
      else if (hit) cfg_q <= data_i[CFG_W-1:0];
   end

   assign cfg_o = cfg_q;

   // R5: a configuration word lands in the register one cycle later
   a_r5_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && code_i == CFG_CODE) |=> cfg_q == $past(data_i[CFG_W-1:0]));
   // R6: without a configuration word the register holds
   a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_i && code_i == CFG_CODE) |=> $stable(cfg_q));

endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top #(
   parameter int unsigned      CMD_W       = 4,
   parameter int unsigned      DATA_W      = 12,
   parameter int unsigned      CFG_W       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [CMD_W-1:0] CFG_CODE    = 4'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_cs_n,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [DATA_W-1:0] cmd_data,
   output logic [CFG_W-1:0]  mode_reg
);
   import cmdrx_pkg::*;

   localparam int unsigned WORD_W = CMD_W + DATA_W;
   localparam logic [2:0]  SYNC_RST = {IDLE_CSN, IDLE_MOSI, IDLE_SCK};

   logic [2:0]        pins_s;
   logic              word_vld;
   logic [WORD_W-1:0] word;

   cmdrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({spi_cs_n, spi_mosi, spi_sck}),
      .sync_o  (pins_s)
   );

   cmdrx_shifter #(.WORD_W(WORD_W), .MSB_FIRST(1'b1)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (pins_s[0]),
      .mosi_s     (pins_s[1]),
      .csn_s      (pins_s[2]),
      .word_vld_o (word_vld),
      .word_o     (word)
   );

   assign cmd_valid = word_vld;
   assign cmd_code  = word[WORD_W-1:DATA_W];
   assign cmd_data  = word[DATA_W-1:0];

   cmdrx_decode #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .CFG_CODE(CFG_CODE)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (word_vld),
      .code_i (cmd_code),
      .data_i (cmd_data),
      .cfg_o  (mode_reg)
   );

   // R9: outputs sit at zero during reset
   a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!cmd_valid && cmd_code == '0 && cmd_data == '0 && mode_reg == '0));

endmodule

// File: tb/cmdrx_top_tb.sv
module cmdrx_top_tb;
   localparam int HALF = 4;   // system clocks per serial half period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
   logic        cmd_valid;
   logic [3:0]  cmd_code;
   logic [11:0] cmd_data;
   logic [7:0]  mode_reg;

   int n_chk = 0, n_bad = 0;
   logic [15:0] exp_q[$];
   logic [7:0]  exp_mode = 8'h00;
   logic [15:0] last_word = 16'h0000;
   logic        prev_v = 1'b0;

   always #2 clk = ~clk;

   cmdrx_top u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_data(cmd_data), .mode_reg(mode_reg)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Driver: sends nbits of val, MSB first; a full word is queued for the monitor
   task automatic send(input logic [31:0] val, input int nbits);
      spi_cs_n = 1'b0;
      tick(HALF);
      for (int i = nbits - 1; i >= 0; i--) begin
         spi_mosi = val[i];
         tick(HALF);
         spi_sck = 1'b1;
         tick(HALF);
         spi_sck = 1'b0;
      end
      tick(HALF);
      if (nbits == 16) begin
         exp_q.push_back(val[15:0]);
         last_word = val[15:0];
         if (val[15:12] == 4'h1) exp_mode = val[7:0];
      end
      spi_cs_n = 1'b1;
      tick(20);
   endtask

   // Monitor: compares each strobed word against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_v) chk(cmd_valid == 1'b0, "R3 strobe width", 32'(cmd_valid), 32'h0);
         if (cmd_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected strobe", {cmd_code, cmd_data}, 32'h0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk(cmd_code == e[15:12], "R2 code field", 32'(cmd_code), 32'(e[15:12]));
               chk(cmd_data == e[11:0], "R1 data bits", 32'(cmd_data), 32'(e[11:0]));
            end
         end
         prev_v = cmd_valid;
      end
   end

   task automatic check_state(input string req);
      chk({cmd_code, cmd_data} == last_word, req, {cmd_code, cmd_data}, last_word);
      chk(mode_reg == exp_mode, req, 32'(mode_reg), 32'(exp_mode));
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      // R9 reset state
      chk(cmd_valid == 1'b0, "R9 valid", 32'(cmd_valid), 32'h0);
      chk(cmd_code == 4'h0, "R9 code", 32'(cmd_code), 32'h0);
      chk(cmd_data == 12'h0, "R9 data", 32'(cmd_data), 32'h0);
      chk(mode_reg == 8'h0, "R9 mode", 32'(mode_reg), 32'h0);
      rst_n = 1'b1;
      tick(5);

      send(32'h3ABC, 16);  check_state("R6 other code keeps mode");
      send(32'h105A, 16);  check_state("R5 mode write");
      send(32'hFFFF, 15);  check_state("R4 short window dropped");
      send(32'h120C3, 17); check_state("R4 long window dropped");

      // R8: clock toggles with select high
      for (int k = 0; k < 16; k++) begin
         spi_mosi = k[0];
         tick(HALF); spi_sck = 1'b1; tick(HALF); spi_sck = 1'b0;
      end
      tick(10);
      check_state("R8 idle clocks ignored");

      send(32'h1F81, 16);  check_state("R5 second mode write");
      send(32'h0000, 16);  check_state("R6 zero code keeps mode");
      send(32'h5AA5, 16);  check_state("R1 pattern 5AA5");
      send(32'hA55A, 16);  check_state("R7 hold after A55A");
      send(32'h1001, 16);  check_state("R5 low mode value");

      chk(exp_q.size() == 0, "R3 strobes delivered", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule